// File: doc/BRIEF.md
# Second-Chance Clock Victim Selector

This block picks which entry to evict from one cache set, or from a small fully associative table of `N` entries. It holds one reference bit for each entry and a circular hand pointer. The surrounding cache controller reports hits by entry index, reports fills, and asks for a victim when a miss needs a slot. The tag and data arrays are not part of this block.

When asked for a victim, the block walks the entries one per cycle, starting at the hand. An entry whose reference bit is set gets a second chance: the walk clears its bit and moves on. The first entry found with a clear bit becomes the victim. The victim index is returned with a one-cycle valid strobe, and the hand is left on the victim. A fill moves the hand to the entry just after the one that was filled.

The control is a two-state machine. `ST_IDLE` waits for work and accepts hits and fills. `ST_SCAN` inspects the entry under the hand once per cycle. The transition `IDLE→SCAN` is taken on a victim request. `SCAN→SCAN` (skip) is taken when the inspected bit is set. `SCAN→IDLE` (found) is taken when it is clear, and it raises the valid strobe on the following cycle.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all reference bits are clear, the hand is at entry 0, `vic_valid` and `busy` are low, and the first victim request returns entry 0.
- R2: A hit (`acc_valid` with `acc_idx`) sets that entry's reference bit, so that entry is skipped by the next scan that reaches it.
- R3: A scan inspects entries in ascending index order from the hand, wrapping from `N-1` to 0, and returns the first entry whose reference bit is clear.
- R4: Every entry that a scan skips has its reference bit cleared.
- R5: If every reference bit is set, the scan goes once around the whole ring and returns the entry it started at. The strobe then appears `N+1` cycles after the request, and a scan never takes longer than that.
- R6: A fill of entry `f` while idle sets `f`'s reference bit and moves the hand to `f+1`, or to 0 when `f` is `N-1`.
- R7: A hit that arrives in the same cycle as a victim request is applied before inspection. A hit on the entry under the hand therefore makes the scan skip that entry.
- R8: `busy` is high from the cycle after a request is accepted until the cycle in which the strobe appears. `vic_valid` is a one-cycle pulse `k+1` cycles after the request, where `k` is the number of entries skipped.
- R9: A scan leaves the hand on the victim, so a second request with no hit or fill in between returns the same entry in one cycle.
- R10: A victim request that arrives while `busy` is high is ignored and produces no extra strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Hit notification |
| acc_idx | input | $clog2(N) | Entry that was hit |
| fill_valid | input | 1 | Fill notification, honoured only while idle |
| fill_idx | input | $clog2(N) | Entry that was filled |
| vic_req | input | 1 | Request for a victim |
| vic_valid | output | 1 | One-cycle strobe marking `vic_idx` valid |
| vic_idx | output | $clog2(N) | Chosen victim entry |
| busy | output | 1 | Scan in progress |

## Verification
The assertions assume that the index inputs are always below `N` and that fills arrive only while `busy` is low, because the block ignores fills during a scan. The bench issues fills only between scans and draws indices from `0..N-1`. It applies hits either alone or in the same cycle as a request, and never in the middle of a scan, so its sequential reference model matches the block cycle for cycle. Repeated requests are driven deliberately while `busy` is high, to show that they are ignored.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } sel_state_e;
endpackage

// File: rtl/clk_ref_bits.sv
module clk_ref_bits #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             fill_ld,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N-1:0]     ref_q,
    output logic [N-1:0]     ref_eff
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic hit_g, fill_g, clr_g;
        assign hit_g  = acc_valid && (acc_idx == IDX_W'(g));
        assign fill_g = fill_ld && (fill_idx == IDX_W'(g));
        assign clr_g  = clr_en && (clr_idx == IDX_W'(g));

        // A hit in this cycle is visible to the scan before it inspects the bit.
        assign ref_eff[g] = ref_q[g] | hit_g;

        always_ff @(posedge clk) begin
            if (!rst_n)
                ref_q[g] <= 1'b0;
            else
                ref_q[g] <= (ref_q[g] | hit_g | fill_g) & ~clr_g;
        end
    end

    // R2
    acc_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !(clr_en && clr_idx == acc_idx)) |=> ref_q[$past(acc_idx)]);

    // R4
    skip_clears_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !ref_q[$past(clr_idx)]);
endmodule

// File: rtl/clk_hand.sv
module clk_hand #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_ld,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr_q
);
    function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] x);
        return (x == IDX_W'(N - 1)) ? '0 : x + IDX_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (fill_ld)
            ptr_q <= ring_next(fill_idx);
        else if (adv)
            ptr_q <= ring_next(ptr_q);
    end

    // R6
    fill_moves_hand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ld |=> (ptr_q == (($past(fill_idx) == IDX_W'(N - 1)) ? '0 : $past(fill_idx) + IDX_W'(1))));

    // R9
    hand_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_ld && !adv) |=> $stable(ptr_q));
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
    import clk_sel_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N),
    localparam int CNT_W = $clog2(N + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             vic_req,
    output logic             vic_valid,
    output logic [IDX_W-1:0] vic_idx,
    output logic             busy
);
    sel_state_e       state, state_nx;
    logic [N-1:0]     ref_q, ref_eff;
    logic [IDX_W-1:0] ptr_q;
    logic             adv, clr_en, found, fill_ld;

    assign fill_ld = fill_valid && (state == ST_IDLE);
    assign busy    = (state == ST_SCAN);

    clk_ref_bits #(.N(N)) u_refs (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_idx(acc_idx),
        .fill_ld(fill_ld), .fill_idx(fill_idx),
        .clr_en(clr_en), .clr_idx(ptr_q),
        .ref_q(ref_q), .ref_eff(ref_eff)
    );

    clk_hand #(.N(N)) u_hand (
        .clk(clk), .rst_n(rst_n),
        .fill_ld(fill_ld), .fill_idx(fill_idx),
        .adv(adv), .ptr_q(ptr_q)
    );

    always_comb begin
        state_nx = state;
        adv      = 1'b0;
        clr_en   = 1'b0;
        found    = 1'b0;
        unique case (state)
            ST_IDLE: if (vic_req) state_nx = ST_SCAN;
            ST_SCAN: begin
                if (ref_eff[ptr_q]) begin
                    clr_en = 1'b1;
                    adv    = 1'b1;
                end else begin
                    found    = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vic_valid <= 1'b0;
            vic_idx   <= '0;
        end else begin
            vic_valid <= found;
            if (found) vic_idx <= ptr_q;
        end
    end

    logic [CNT_W-1:0] scan_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_SCAN) scan_cnt <= '0;
        else                            scan_cnt <= scan_cnt + CNT_W'(1);
    end

    // R5
    scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |-> (scan_cnt <= CNT_W'(N)));

    // R3
    victim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> !ref_q[vic_idx]);

    // R8
    strobe_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> ($past(state) == ST_SCAN) && !busy);

    // R10
    no_double_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |=> !vic_valid);
endmodule

// File: tb/clock_victim_sel_tb.sv
module clock_victim_sel_tb;
    localparam int N = 8;
    localparam int IDX_W = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, fill_valid = 1'b0, vic_req = 1'b0;
    logic [IDX_W-1:0] acc_idx = '0, fill_idx = '0;
    logic vic_valid, busy;
    logic [IDX_W-1:0] vic_idx;

    always #5 clk = ~clk;

    clock_victim_sel #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_idx(acc_idx),
        .fill_valid(fill_valid), .fill_idx(fill_idx),
        .vic_req(vic_req), .vic_valid(vic_valid),
        .vic_idx(vic_idx), .busy(busy)
    );

    typedef struct {
        int    idx;
        int    lat;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0, n_bad = 0;
    int   cyc = 0, start_cyc = 0;
    bit   mref[N];
    int   mptr = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Monitor: compares each strobe with the next expected item.
    always @(negedge clk) begin
        if (rst_n && vic_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected strobe", int'(vic_idx), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'(vic_idx) == e.idx, {e.tag, " victim"}, int'(vic_idx), e.idx);
                chk(cyc - start_cyc == e.lat, {e.tag, " R8 latency"}, cyc - start_cyc, e.lat);
            end
        end
    end

    task automatic access(input int i);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = IDX_W'(i);
        mref[i] = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic fill(input int i);
        @(negedge clk);
        fill_valid = 1'b1; fill_idx = IDX_W'(i);
        mref[i] = 1'b1;
        mptr = (i + 1) % N;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Driver: computes the expected victim from the requirements, then issues the request.
    task automatic victim(input bit with_acc, input int acc_i, input bit dup, input string tag);
        exp_t e;
        int p, k;
        if (with_acc) mref[acc_i] = 1'b1;
        p = mptr; k = 1;
        while (mref[p]) begin
            mref[p] = 1'b0;
            p = (p + 1) % N;
            k++;
        end
        mptr = p;
        e.idx = p; e.lat = k; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        vic_req = 1'b1;
        if (with_acc) begin acc_valid = 1'b1; acc_idx = IDX_W'(acc_i); end
        @(negedge clk);
        vic_req = 1'b0; acc_valid = 1'b0;
        start_cyc = cyc;
        if (k > 1) chk(busy == 1'b1, {tag, " R8 busy"}, int'(busy), 1);
        if (dup) begin
            @(negedge clk); vic_req = 1'b1;
            @(negedge clk); vic_req = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, {tag, " R8 idle"}, int'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) mref[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk(vic_valid == 1'b0, "R1 strobe low", int'(vic_valid), 0);
        chk(busy == 1'b0, "R1 busy low", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        victim(0, 0, 0, "R1 first victim");
        fill(0);
        victim(0, 0, 0, "R6 after fill");
        victim(0, 0, 0, "R9 repeat");
        access(1); access(2); access(3);
        victim(0, 0, 0, "R2 R3 skip hits");
        fill(7);
        victim(0, 0, 0, "R4 R6 cleared bits");
        for (int i = 0; i < N; i++) access(i);
        victim(0, 0, 1, "R5 R10 full wrap");
        fill(N - 1);
        victim(0, 0, 0, "R6 wrap hand");
        victim(1, mptr, 0, "R7 same-cycle hit");
        for (int t = 0; t < 40; t++) begin
            int op, i;
            op = int'($urandom % 3);
            i  = int'($urandom % N);
            if (op == 0)      access(i);
            else if (op == 1) fill(i);
            else              victim(0, 0, 0, "R3 random");
        end
        victim(0, 0, 0, "R3 final");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule